// File: doc/BRIEF.md
# ATAPI PIO Packet Transfer Sequencer

This block is the device-side engine of a packet command carried out with programmed I/O. The host first loads a transfer size limit into the two byte-count registers. It then writes the packet opcode to the command register and sends a 12-byte command packet as six 16-bit writes to the data port. The engine decodes a block-read request from that packet: the opcode, a 32-bit start block and a 16-bit block count. It then hands the requested data back to the host in bursts. Before each burst it raises an interrupt, and it raises one more interrupt after the final word.

Data words come from a simple synchronous source. The engine drives a registered word address, and the source answers with the matching word in the same cycle. During a burst, each read of the data port returns the current word and moves the address forward by one.

The sequencer has four states:
- `ST_IDLE`: ready, status shows only the ready bit.
- `ST_PKT`: collecting the packet.
- `ST_HOLD`: busy for a fixed number of cycles after the packet has arrived.
- `ST_XFER`: a burst is open.

It moves between them as follows:
- `ST_IDLE` goes to `ST_PKT` on a packet command.
- `ST_PKT` goes to `ST_HOLD` on the sixth packet word.
- `ST_HOLD` goes to `ST_XFER` when the hold expires and data is due. If no data is due, it goes straight back to `ST_IDLE` and raises the completion interrupt.
- `ST_XFER` stays in `ST_XFER` at the end of a burst while data remains, and opens the next burst.
- `ST_XFER` goes to `ST_IDLE` after the last word.

Top module: `atapi_pio_seq`

## Requirements
- R1: After reset the status register (address 7) reads 0x40, `intrq` is low and the engine is idle.
- R2: Writing 0xA0 to address 7 while idle starts a packet command. The limit is captured from address 4 (low byte) and address 5 (high byte). Any other value written to address 7 leaves the engine idle with status 0x40.
- R3: After the packet command, status reads 0x48 until six data-port (address 0) writes have arrived. The status bits are: bit 7 busy, bit 6 ready, bit 5 device fault, bit 3 data request, bit 0 error. Busy and data request are never set together.
- R4: Each packet word carries its low byte first. Byte 0 is the opcode; 0x28 requests a read. Bytes 2..5 hold the start block, most significant byte first. Bytes 7..8 hold the block count, most significant byte first. The total length is the block count times 2048 bytes.
- R5: After the sixth packet word, status reads 0xC0 for exactly HOLD_CYCLES+1 cycles before any burst or completion.
- R6: Each burst is the smaller of the bytes remaining and the limit with bit 0 cleared. If that cleared limit is zero, 0xFFFE is used. While a burst is open, addresses 4 and 5 read back its byte count.
- R7: At the start of every burst `intrq` rises and status reads 0x48. Each data-port read returns the source word at word address start_block*1024 + n, where n counts the words read so far in the command.
- R8: A read of address 7 clears `intrq`. Reads of other addresses leave it set.
- R9: After the last word of the last burst, `intrq` rises and status reads 0x40.
- R10: A block count of zero, or an opcode other than 0x28, produces no data phase. After the hold, only the completion interrupt is raised and status reads 0x40.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Host register write strobe |
| rd_en | input | 1 | Host register read strobe |
| addr | input | 3 | Host register address |
| wdata | input | 16 | Host write data |
| rdata | output | 16 | Host read data, valid in the cycle of `rd_en` |
| intrq | output | 1 | Interrupt request to the host |
| src_addr | output | SRC_AW (42) | Word address presented to the data source |
| src_data | input | 16 | Word returned by the source for `src_addr` |

## Verification
The assertions assume the host asserts at most one of `wr_en` and `rd_en` in a cycle. They also assume the data port is read only while a burst is open, and that the host waits for `intrq` before reading status at the start of a burst. The bench drives every access through single-strobe tasks that never overlap. Its transfer routine waits for the interrupt before each burst and reads exactly the announced number of words. Random limits, start blocks and block counts are drawn within those rules.

// File: rtl/atapi_pio_pkg.sv
package atapi_pio_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PKT  = 2'd1,
        ST_HOLD = 2'd2,
        ST_XFER = 2'd3
    } seq_state_e;

    localparam logic [2:0] RA_DATA = 3'd0;
    localparam logic [2:0] RA_BCL  = 3'd4;
    localparam logic [2:0] RA_BCH  = 3'd5;
    localparam logic [2:0] RA_CMD  = 3'd7;

    localparam logic [7:0] OPC_PACKET = 8'hA0;
    localparam logic [7:0] OPC_READ10 = 8'h28;

    localparam int SB_BSY  = 7;
    localparam int SB_DRDY = 6;
    localparam int SB_DF   = 5;
    localparam int SB_DRQ  = 3;
    localparam int SB_ERR  = 0;

    localparam int PKT_WORDS = 6;
    localparam int LBA_BITS  = 32;
    localparam int CNT_BITS  = 16;
endpackage

// File: rtl/atapi_pkt_capture.sv
module atapi_pkt_capture
    import atapi_pio_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                word_we,
    input  logic [15:0]         word_in,
    output logic                done,
    output logic [7:0]          opcode,
    output logic [LBA_BITS-1:0] blk_addr,
    output logic [CNT_BITS-1:0] blk_cnt
);
    localparam int IDX_W = $clog2(PKT_WORDS);

    logic [IDX_W-1:0] idx_q;

    assign done = word_we && (idx_q == IDX_W'(PKT_WORDS - 1));

    // Words arrive low byte first; address and count fields are MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q    <= '0;
            opcode   <= '0;
            blk_addr <= '0;
            blk_cnt  <= '0;
        end else if (start) begin
            idx_q <= '0;
        end else if (word_we) begin
            idx_q <= done ? '0 : idx_q + 1'b1;
            unique case (idx_q)
                IDX_W'(0): opcode               <= word_in[7:0];
                IDX_W'(1): blk_addr[31:16]      <= {word_in[7:0], word_in[15:8]};
                IDX_W'(2): blk_addr[15:0]       <= {word_in[7:0], word_in[15:8]};
                IDX_W'(3): blk_cnt[15:8]        <= word_in[15:8];
                IDX_W'(4): blk_cnt[7:0]         <= word_in[7:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/atapi_burst_size.sv
module atapi_burst_size #(
    parameter int LEN_W = 27
) (
    input  logic [LEN_W-1:0] remaining,
    input  logic [15:0]      raw_limit,
    output logic [15:0]      eff_limit,
    output logic [15:0]      size
);
    logic [15:0] even_limit;

    assign even_limit = {raw_limit[15:1], 1'b0};
    assign eff_limit  = (even_limit == 16'd0) ? 16'hFFFE : even_limit;
    assign size       = (remaining < LEN_W'(eff_limit)) ? remaining[15:0] : eff_limit;
endmodule

// File: rtl/atapi_pio_seq.sv
module atapi_pio_seq
    import atapi_pio_pkg::*;
#(
    parameter  int BLK_BYTES_LOG2 = 11,
    parameter  int HOLD_CYCLES    = 8,
    localparam int SRC_AW         = LBA_BITS + BLK_BYTES_LOG2 - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [2:0]        addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              intrq,
    output logic [SRC_AW-1:0] src_addr,
    input  logic [15:0]       src_data
);
    localparam int LEN_W  = CNT_BITS + BLK_BYTES_LOG2;
    localparam int WL     = BLK_BYTES_LOG2 - 1;
    localparam int HOLD_W = $clog2(HOLD_CYCLES + 1);

    seq_state_e        state_q, state_d;
    logic [7:0]        bcl_q, bch_q;
    logic [15:0]       lim_q;
    logic [LEN_W-1:0]  remain_q;
    logic [15:0]       burst_q;
    logic [SRC_AW-1:0] waddr_q;
    logic [HOLD_W-1:0] hold_q;
    logic [7:0]        status;

    logic                cmd_wr, pkt_wr, data_rd, stat_rd;
    logic                pkt_done, hold_end, burst_end, burst_load, irq_set;
    logic [7:0]          pkt_opc;
    logic [LBA_BITS-1:0] pkt_lba;
    logic [CNT_BITS-1:0] pkt_cnt;
    logic [15:0]         eff_limit, next_size;

    assign cmd_wr   = wr_en && addr == RA_CMD && state_q == ST_IDLE && wdata[7:0] == OPC_PACKET;
    assign pkt_wr   = wr_en && addr == RA_DATA && state_q == ST_PKT;
    assign data_rd  = rd_en && addr == RA_DATA && state_q == ST_XFER;
    assign stat_rd  = rd_en && addr == RA_CMD;

    assign hold_end   = state_q == ST_HOLD && hold_q == '0;
    assign burst_end  = data_rd && burst_q == 16'd2;
    assign burst_load = (hold_end || burst_end) && remain_q != '0;
    assign irq_set    = hold_end || burst_end;

    atapi_pkt_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (cmd_wr),
        .word_we  (pkt_wr),
        .word_in  (wdata),
        .done     (pkt_done),
        .opcode   (pkt_opc),
        .blk_addr (pkt_lba),
        .blk_cnt  (pkt_cnt)
    );

    atapi_burst_size #(.LEN_W(LEN_W)) u_size (
        .remaining (remain_q),
        .raw_limit (lim_q),
        .eff_limit (eff_limit),
        .size      (next_size)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (cmd_wr)   state_d = ST_PKT;
            ST_PKT:  if (pkt_done) state_d = ST_HOLD;
            ST_HOLD: if (hold_end) state_d = (remain_q == '0) ? ST_IDLE : ST_XFER;
            ST_XFER: if (burst_end && remain_q == '0) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath and interrupt
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bcl_q    <= '0;
            bch_q    <= '0;
            lim_q    <= '0;
            remain_q <= '0;
            burst_q  <= '0;
            waddr_q  <= '0;
            hold_q   <= '0;
            intrq    <= 1'b0;
        end else begin
            if (wr_en && state_q == ST_IDLE && addr == RA_BCL) bcl_q <= wdata[7:0];
            if (wr_en && state_q == ST_IDLE && addr == RA_BCH) bch_q <= wdata[7:0];
            if (cmd_wr) lim_q <= {bch_q, bcl_q};
            if (pkt_done) begin
                hold_q   <= HOLD_W'(HOLD_CYCLES);
                waddr_q  <= {pkt_lba, {WL{1'b0}}};
                remain_q <= (pkt_opc == OPC_READ10) ? {pkt_cnt, {BLK_BYTES_LOG2{1'b0}}} : '0;
            end else if (state_q == ST_HOLD && hold_q != '0) begin
                hold_q <= hold_q - 1'b1;
            end
            if (burst_load) begin
                burst_q  <= next_size;
                remain_q <= remain_q - LEN_W'(next_size);
            end else if (data_rd) begin
                burst_q <= burst_q - 16'd2;
            end
            if (data_rd) waddr_q <= waddr_q + 1'b1;
            if (irq_set)      intrq <= 1'b1;
            else if (stat_rd) intrq <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        status = 8'h00;
        unique case (state_q)
            ST_IDLE: status[SB_DRDY] = 1'b1;
            ST_PKT:  begin status[SB_DRDY] = 1'b1; status[SB_DRQ] = 1'b1; end
            ST_HOLD: begin status[SB_DRDY] = 1'b1; status[SB_BSY] = 1'b1; end
            ST_XFER: begin status[SB_DRDY] = 1'b1; status[SB_DRQ] = 1'b1; end
            default: status = 8'h00;
        endcase
        unique case (addr)
            RA_DATA: rdata = (state_q == ST_XFER) ? src_data : 16'h0000;
            RA_BCL:  rdata = {8'h00, (state_q == ST_XFER) ? burst_q[7:0]  : bcl_q};
            RA_BCH:  rdata = {8'h00, (state_q == ST_XFER) ? burst_q[15:8] : bch_q};
            RA_CMD:  rdata = {8'h00, status};
            default: rdata = 16'h0000;
        endcase
    end

    assign src_addr = waddr_q;
endmodule

// File: rtl/atapi_pio_seq_chk.sv
module atapi_pio_seq_chk
    import atapi_pio_pkg::*;
#(
    parameter int HOLD_CYCLES = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [2:0]  addr,
    input logic [7:0]  cmd_byte,
    input logic        intrq,
    input seq_state_e  state,
    input logic [7:0]  status,
    input logic [15:0] burst_left,
    input logic [15:0] eff_limit
);
    localparam int RUN_W = $clog2(HOLD_CYCLES + 3);

    logic [RUN_W-1:0] hold_run;

    always_ff @(posedge clk) begin
        if (!rst_n)                 hold_run <= '0;
        else if (state == ST_HOLD)  hold_run <= hold_run + 1'b1;
        else                        hold_run <= '0;
    end

    // R8: status read outside the hold clears the interrupt
    a_r8_stat_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == RA_CMD && state != ST_HOLD) |=> !intrq);

    // R3: busy and data request are exclusive
    a_r3_busy_no_drq: assert property (@(posedge clk) disable iff (!rst_n)
        status[SB_BSY] |-> (!status[SB_DRQ] && status[SB_DRDY]));

    // R6: open burst is even, nonzero and within the limit
    a_r6_burst_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_XFER) |-> (burst_left[0] == 1'b0 && burst_left != 16'd0 && burst_left <= eff_limit));

    // R2: other command values leave the engine idle
    a_r2_other_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && wr_en && addr == RA_CMD && cmd_byte != OPC_PACKET) |=> state == ST_IDLE);

    // R7 / R9: interrupts rise only at the end of the hold or of a burst
    a_r9_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(intrq) |-> ($past(state) == ST_HOLD || $past(state) == ST_XFER));

    // R5: the hold never exceeds HOLD_CYCLES+1 cycles
    a_r5_hold_len: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD) |-> hold_run <= RUN_W'(HOLD_CYCLES));

    a_r5_hold_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HOLD && hold_run == RUN_W'(HOLD_CYCLES)) |=> state != ST_HOLD);
endmodule

bind atapi_pio_seq atapi_pio_seq_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .cmd_byte   (wdata[7:0]),
    .intrq      (intrq),
    .state      (state_q),
    .status     (status),
    .burst_left (burst_q),
    .eff_limit  (eff_limit)
);

// File: tb/atapi_pio_seq_bench.sv
module atapi_pio_seq_bench;
    localparam int SAW = 42;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic           rd_en = 1'b0;
    logic [2:0]     addr = 3'd0;
    logic [15:0]    wdata = 16'h0;
    logic [15:0]    rdata;
    logic           intrq;
    logic [SAW-1:0] src_addr;
    logic [15:0]    src_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    function automatic logic [15:0] src_fn(input logic [SAW-1:0] a);
        return a[15:0] ^ a[31:16] ^ {6'b0, a[41:32]} ^ 16'h5A3C;
    endfunction

    assign src_data = src_fn(src_addr);

    atapi_pio_seq u_atapi_pio_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .rdata    (rdata),
        .intrq    (intrq),
        .src_addr (src_addr),
        .src_data (src_data)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic host_rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic wait_intr(input string tag);
        int n = 0;
        while (!intrq && n < 200) begin
            @(negedge clk);
            n++;
        end
        check(intrq == 1'b1, tag, 32'(intrq), 32'd1);
    endtask

    function automatic logic [15:0] eff_lim(input logic [15:0] l);
        logic [15:0] e = {l[15:1], 1'b0};
        return (e == 16'd0) ? 16'hFFFE : e;
    endfunction

    task automatic run_xfer(input logic [31:0] lba, input logic [15:0] nblk,
                            input logic [15:0] lim, input logic [7:0] opc);
        logic [7:0]  pk [0:11];
        logic [15:0] d, lo, hi;
        logic [31:0] total, remaining, burst, j, bad, first_act, first_exp;
        for (int i = 0; i < 12; i++) pk[i] = 8'h00;
        pk[0] = opc;
        pk[2] = lba[31:24]; pk[3] = lba[23:16]; pk[4] = lba[15:8]; pk[5] = lba[7:0];
        pk[7] = nblk[15:8]; pk[8] = nblk[7:0];
        host_wr(3'd4, {8'h00, lim[7:0]});
        host_wr(3'd5, {8'h00, lim[15:8]});
        host_wr(3'd7, 16'h00A0);
        host_rd(3'd7, d);
        check(d[7:0] == 8'h48, "R3 packet phase status", 32'(d[7:0]), 32'h48);
        check(intrq == 1'b0, "R3 no interrupt in packet phase", 32'(intrq), 32'd0);
        for (int k = 0; k < 6; k++) host_wr(3'd0, {pk[2*k+1], pk[2*k]});
        host_rd(3'd7, d);
        check(d[7:0] == 8'hC0, "R5 busy after packet", 32'(d[7:0]), 32'hC0);
        total = (opc == 8'h28) ? 32'(nblk) * 32'd2048 : 32'd0;
        remaining = total;
        j = 0; bad = 0; first_act = 0; first_exp = 0;
        while (remaining > 0) begin
            burst = (remaining < 32'(eff_lim(lim))) ? remaining : 32'(eff_lim(lim));
            wait_intr("R7 burst interrupt");
            host_rd(3'd4, lo);
            check(intrq == 1'b1, "R8 non-status read keeps interrupt", 32'(intrq), 32'd1);
            host_rd(3'd5, hi);
            check({hi[7:0], lo[7:0]} == burst[15:0], "R6 burst byte count",
                  32'({hi[7:0], lo[7:0]}), burst);
            host_rd(3'd7, d);
            check(d[7:0] == 8'h48, "R7 burst status", 32'(d[7:0]), 32'h48);
            check(intrq == 1'b0, "R8 status read clears interrupt", 32'(intrq), 32'd0);
            for (int w = 0; w < int'(burst / 2); w++) begin
                host_rd(3'd0, d);
                if (d != src_fn({lba, 10'b0} + SAW'(j))) begin
                    if (bad == 0) begin
                        first_act = 32'(d);
                        first_exp = 32'(src_fn({lba, 10'b0} + SAW'(j)));
                    end
                    bad++;
                end
                j++;
            end
            remaining -= burst;
        end
        check(bad == 0, "R7 data words", first_act, first_exp);
        check(j == total / 2, "R4 total words", j, total / 2);
        wait_intr(total == 0 ? "R10 completion interrupt" : "R9 completion interrupt");
        host_rd(3'd7, d);
        check(d[7:0] == 8'h40, total == 0 ? "R10 final status" : "R9 final status", 32'(d[7:0]), 32'h40);
        check(intrq == 1'b0, "R8 final clear", 32'(intrq), 32'd0);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles >= 190000 && !finished) begin
                errors++;
                $display("FAIL watchdog act=%0d exp=done", cycles);
                $display("CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        logic [15:0] d;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        host_rd(3'd7, d);
        check(d[7:0] == 8'h40, "R1 reset status", 32'(d[7:0]), 32'h40);
        check(intrq == 1'b0, "R1 reset interrupt", 32'(intrq), 32'd0);
        // R2 other command values ignored
        host_wr(3'd7, 16'h00EC);
        host_wr(3'd0, 16'h1234);
        host_rd(3'd7, d);
        check(d[7:0] == 8'h40, "R2 other command ignored", 32'(d[7:0]), 32'h40);
        check(intrq == 1'b0, "R2 no interrupt on ignored command", 32'(intrq), 32'd0);
        // Directed cases
        run_xfer(32'd0,     16'd1,  16'd5120, 8'h28);  // R4 single burst
        run_xfer(32'd7,     16'd10, 16'd5120, 8'h28);  // R6 exact multiple, 4 bursts
        run_xfer(32'h01020304, 16'd2, 16'd5121, 8'h28);// R6 odd limit
        run_xfer(32'd99,    16'd1,  16'd1,    8'h28);  // R6 limit rounds to zero
        run_xfer(32'd5,     16'd0,  16'd512,  8'h28);  // R10 zero blocks
        run_xfer(32'd5,     16'd3,  16'd512,  8'h12);  // R10 other opcode
        run_xfer(32'hFFFFFFF0, 16'd33, 16'd0, 8'h28);  // R6 zero limit, 0xFFFE bursts
        // Random cases
        for (int r = 0; r < 5; r++) begin
            run_xfer($urandom, 16'($urandom_range(1, 3)), 16'($urandom_range(2, 6000)), 8'h28);
        end
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule